// File: doc/BRIEF.md
# Paired Mealy and Moore Sequence Recogniser

This block holds two finite-state machines that receive the same one-bit input stream. The first is a five-state Mealy machine with the letters A to E. Its output `mealy_z` depends on the current letter and on the input in the same cycle. The second is a Moore machine that gives the same output sequence. It has six states because the D letter is split into two copies, one for each output value with which D can be entered. Its output `moore_z` comes from the state register alone, so it arrives one clock later than the Mealy output.

Both machines reset synchronously on the same rising edge. The input is a plain control pin that is sampled on every rising edge, with no handshake. Both machines also bring their state out on ports so that the state can be observed.

Top module: `seq_pair_top`

## Requirements
- R1: While `rst` is high at a rising edge, the Mealy letter becomes A (code 0) and the Moore code becomes A/0 (code 0). In the cycle after that edge, both `mealy_z` and `moore_z` are 0.
- R2: `mealy_z` is 1 only in letter C with `x_in`=0 or in letter D with `x_in`=0. It is combinational, so it follows a change of `x_in` within the same cycle.
- R3: The Mealy letters are coded A=0, B=1, C=2, D=3, E=4. With x=0 the next letters are A→B, B→E, C→D, D→C, E→B. With x=1 they are A→E, B→D, C→A, D→E, E→D.
- R4: The Moore codes are A/0=0, B/0=1, C/1=2, D/0=3, D/1=4, E/0=5. The next Moore state is the Mealy next letter of the current letter, paired with the Mealy output of that step. In particular, D/1 is entered only from C/1 with x=0.
- R5: `moore_z` is 1 exactly in codes 2 and 4. It does not change when `x_in` changes within a cycle.
- R6: For any input stream after reset, `moore_z` in cycle n+1 equals `mealy_z` in cycle n.
- R7: The letter of the Moore state always equals the Mealy letter. Codes 3 and 4 both count as letter D.
- R8: `moore_code` never takes the values 6 or 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| x_in | input | 1 | Input symbol, sampled on every edge |
| mealy_z | output | 1 | Mealy output (combinational) |
| moore_z | output | 1 | Moore output (registered) |
| mealy_letter | output | 3 | Current Mealy letter code |
| moore_code | output | 3 | Current Moore state code |

## Verification
`mealy_z` is due in the same cycle as the input that produces it. The driver therefore checks it a few nanoseconds after it changes `x_in`, before the next rising edge. Every expected Mealy output is also pushed into a queue. One clock later, the monitor pops the entry at the falling edge and compares it with `moore_z`, which matches the single register stage of the Moore machine. The state codes change one edge after their input and are checked against a reference walk that the bench steps at the same points.

// File: rtl/seq_pair_pkg.sv
package seq_pair_pkg;
  localparam int LETTER_W = 3;
  localparam int CODE_W   = 3;

  typedef enum logic [LETTER_W-1:0] {
    L_A = 3'd0, L_B = 3'd1, L_C = 3'd2, L_D = 3'd3, L_E = 3'd4
  } letter_e;

  typedef enum logic [CODE_W-1:0] {
    M_A0 = 3'd0, M_B0 = 3'd1, M_C1 = 3'd2, M_D0 = 3'd3, M_D1 = 3'd4, M_E0 = 3'd5
  } mcode_e;

  typedef struct packed {
    letter_e nxt;
    logic    z;
  } step_t;

  // One Mealy step: next letter and output for a letter and an input bit.
  function automatic step_t mealy_step(letter_e s, logic x);
    step_t r;
    r.z = 1'b0;
    unique case (s)
      L_A: r.nxt = x ? L_E : L_B;
      L_B: r.nxt = x ? L_D : L_E;
      L_C: begin r.nxt = x ? L_A : L_D; r.z = ~x; end
      L_D: begin r.nxt = x ? L_E : L_C; r.z = ~x; end
      L_E: r.nxt = x ? L_D : L_B;
      default: r.nxt = L_A;
    endcase
    return r;
  endfunction

  // Moore state reached by a Mealy step: letter split by arrival output.
  function automatic mcode_e split_code(step_t t);
    mcode_e c;
    unique case (t.nxt)
      L_A: c = M_A0;
      L_B: c = M_B0;
      L_C: c = M_C1;
      L_D: c = t.z ? M_D1 : M_D0;
      L_E: c = M_E0;
      default: c = M_A0;
    endcase
    return c;
  endfunction

  function automatic letter_e code_letter(mcode_e c);
    letter_e l;
    unique case (c)
      M_A0: l = L_A;
      M_B0: l = L_B;
      M_C1: l = L_C;
      M_D0, M_D1: l = L_D;
      M_E0: l = L_E;
      default: l = L_A;
    endcase
    return l;
  endfunction

  function automatic logic code_z(mcode_e c);
    return (c == M_C1) || (c == M_D1);
  endfunction
endpackage

// File: rtl/mealy_fsm.sv
module mealy_fsm
  import seq_pair_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                x_in,
  output logic                z_out,
  output logic [LETTER_W-1:0] letter_out
);
  letter_e state_q;
  step_t   step_c;

  always_comb step_c = mealy_step(state_q, x_in);

  always_ff @(posedge clk) begin
    if (rst) state_q <= L_A;
    else     state_q <= step_c.nxt;
  end

  assign z_out      = step_c.z;
  assign letter_out = state_q;

  // R2: a one on the Mealy output requires a zero input
  p_z_needs_x0_r2: assert property (@(posedge clk) disable iff (rst)
    z_out |-> !x_in);
endmodule

// File: rtl/moore_fsm.sv
module moore_fsm
  import seq_pair_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              x_in,
  output logic              z_out,
  output logic [CODE_W-1:0] code_out
);
  mcode_e  code_q;
  mcode_e  code_d;
  letter_e cur_letter;

  always_comb begin
    cur_letter = code_letter(code_q);
    code_d     = split_code(mealy_step(cur_letter, x_in));
  end

  always_ff @(posedge clk) begin
    if (rst) code_q <= M_A0;
    else     code_q <= code_d;
  end

  assign z_out    = code_z(code_q);
  assign code_out = code_q;

  // R4: the one-output copy of D is entered only from C/1 with x=0
  p_d1_from_c_r4: assert property (@(posedge clk) disable iff (rst)
    (code_out == M_D1) |-> ($past(code_out) == M_C1 && !$past(x_in)));

  // R8: the two spare codes never appear
  p_legal_code_r8: assert property (@(posedge clk) disable iff (rst)
    code_out <= M_E0);
endmodule

// File: rtl/seq_pair_top.sv
module seq_pair_top
  import seq_pair_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              x_in,
  output logic              mealy_z,
  output logic              moore_z,
  output logic [LETTER_W-1:0] mealy_letter,
  output logic [CODE_W-1:0]   moore_code
);
  mealy_fsm u_mealy (
    .clk(clk), .rst(rst), .x_in(x_in),
    .z_out(mealy_z), .letter_out(mealy_letter)
  );

  moore_fsm u_moore (
    .clk(clk), .rst(rst), .x_in(x_in),
    .z_out(moore_z), .code_out(moore_code)
  );

  // High once the previous cycle was out of reset.
  logic run_q;
  always_ff @(posedge clk) begin
    if (rst) run_q <= 1'b0;
    else     run_q <= 1'b1;
  end

  // R6: the Moore output is the Mealy output one clock late
  p_delayed_match_r6: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (moore_z == $past(mealy_z)));

  // R7: both machines sit on the same letter
  p_letter_match_r7: assert property (@(posedge clk) disable iff (rst)
    code_letter(mcode_e'(moore_code)) == letter_e'(mealy_letter));

  // R1: both outputs are low in the first cycle after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!moore_z && !mealy_z));
endmodule

// File: tb/seq_pair_top_tb_top.sv
`timescale 1ns/1ps
module seq_pair_top_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic x_in = 1'b0;
  logic mealy_z, moore_z;
  logic [2:0] mealy_letter, moore_code;

  int n_checks = 0;
  int n_fail = 0;
  bit mon_en = 1'b0;
  bit exp_q[$];

  logic [2:0] m_let;
  logic       m_zprev;

  always #4 clk = ~clk;

  seq_pair_top dut_i (
    .clk(clk), .rst(rst), .x_in(x_in),
    .mealy_z(mealy_z), .moore_z(moore_z),
    .mealy_letter(mealy_letter), .moore_code(moore_code)
  );

  function automatic logic [2:0] ref_next(logic [2:0] l, logic x);
    case (l)
      3'd0: return x ? 3'd4 : 3'd1;
      3'd1: return x ? 3'd3 : 3'd4;
      3'd2: return x ? 3'd0 : 3'd3;
      3'd3: return x ? 3'd4 : 3'd2;
      default: return x ? 3'd3 : 3'd1;
    endcase
  endfunction

  function automatic logic ref_z(logic [2:0] l, logic x);
    return ((l == 3'd2) || (l == 3'd3)) && !x;
  endfunction

  function automatic logic [2:0] ref_code(logic [2:0] l, logic zp);
    case (l)
      3'd0: return 3'd0;
      3'd1: return 3'd1;
      3'd2: return 3'd2;
      3'd3: return zp ? 3'd4 : 3'd3;
      default: return 3'd5;
    endcase
  endfunction

  function automatic logic [2:0] ref_letter_of(logic [2:0] c);
    case (c)
      3'd0: return 3'd0;
      3'd1: return 3'd1;
      3'd2: return 3'd2;
      3'd3, 3'd4: return 3'd3;
      3'd5: return 3'd4;
      default: return 3'd7;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor: pops the Mealy output recorded one cycle earlier (R6).
  always @(negedge clk) begin
    if (mon_en && exp_q.size() > 0) begin
      bit e;
      e = exp_q.pop_front();
      chk(moore_z == e, "R6 moore_z vs delayed mealy_z", moore_z, e);
    end
  end

  task automatic do_reset();
    mon_en = 1'b0;
    exp_q.delete();
    rst = 1'b1;
    x_in = 1'b1;
    repeat (2) @(negedge clk);
    chk(mealy_letter == 3'd0, "R1 mealy letter in reset", mealy_letter, 0);
    chk(moore_code == 3'd0, "R1 moore code in reset", moore_code, 0);
    chk(moore_z == 1'b0, "R1 moore_z in reset", moore_z, 0);
    chk(mealy_z == 1'b0, "R1 mealy_z in reset", mealy_z, 0);
    rst = 1'b0;
    m_let = 3'd0;
    m_zprev = 1'b0;
    mon_en = 1'b1;
  endtask

  // Driver: applies one input bit, checks the same-cycle results, queues R6.
  task automatic step(input logic v);
    logic zhold;
    logic ez;
    logic [2:0] ec;
    #1 x_in = ~v;
    #1 zhold = moore_z;
    x_in = v;
    #1;
    chk(moore_z == zhold, "R5 moore_z unaffected by x_in", moore_z, zhold);
    ez = ref_z(m_let, v);
    ec = ref_code(m_let, m_zprev);
    chk(mealy_z == ez, "R2 mealy_z", mealy_z, ez);
    chk(mealy_letter == m_let, "R3 mealy letter", mealy_letter, m_let);
    chk(moore_code == ec, "R4 moore code", moore_code, ec);
    chk(moore_z == ((ec == 3'd2) || (ec == 3'd4)), "R5 moore_z from code",
        moore_z, ((ec == 3'd2) || (ec == 3'd4)));
    chk(ref_letter_of(moore_code) == mealy_letter, "R7 letters agree",
        ref_letter_of(moore_code), mealy_letter);
    chk(moore_code < 3'd6, "R8 legal code", moore_code, 5);
    exp_q.push_back(ez);
    m_zprev = ez;
    m_let = ref_next(m_let, v);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [11:0] walk;
    do_reset();
    // Directed walk: reaches C, both copies of D, and A again.
    walk = 12'b001111_100010;
    for (int i = 0; i < 12; i++) step(walk[i]);
    for (int i = 0; i < 3000; i++) step(1'($urandom_range(0, 1)));
    do_reset();
    for (int i = 0; i < 8; i++) step(1'b0);
    for (int i = 0; i < 8; i++) step(1'b1);
    for (int i = 0; i < 500; i++) step(1'($urandom_range(0, 1)));
    step(1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule